// File: doc/BRIEF.md
# Score Display Controller with Jump Blink

This block turns an unsigned binary score into four decimal digits on active-low seven-segment outputs. A control state machine waits in an idle state until the score input differs from the value it last took up. When the score changes, the block starts a conversion. It finds each decimal digit in turn, from thousands down to units, by subtracting that position's power of ten and counting how many times it can do so. One state handles each digit position. The display registers keep their old contents until the conversion has finished.

A score above 9999 does not fit on four digits. In that case the block skips the conversion and shows a dash on every digit. When a score that fits has risen by at least 25 over the last value taken up, the new digits are announced by blinking. The display goes fully blank and then shows the digits, for a fixed number of cycles in each phase, and this pair of phases repeats a fixed number of times. The block then shows the digits one last time and returns to idle. The blink length and the repeat count are module parameters. Digit multiplexing is not part of this block, because each digit has its own output vector.

Top module: `score_display`

## Requirements
- R1: Each output vector is active low, with bit 0 = segment a through bit 6 = segment g. The units digit drives `seg0` and the thousands digit drives `seg3`. The digits 0 to 9 show the usual patterns (gfedcba lit sets 3F,06,5B,4F,66,6D,7D,07,7F,6F, sent out inverted). Leading zeros are shown as 0.
- R2: A synchronous active-high reset blanks all four digits (7'h7F each), sets the reference score to 0 and returns the machine to idle. With score 0 after reset, the display stays blank.
- R3: While the score equals the reference score, the outputs do not change.
- R4: After a change to a score of 9999 or less, the display settles on the decimal digits of that score.
- R5: After a change to a score above 9999, all four digits show a dash (7'h3F, only segment g lit).
- R6: If a fitting score exceeds the reference by 25 or more, the display blinks before it settles. There are BLINK_COUNT blank runs, each exactly BLINK_INTERVAL cycles long, and each is followed by BLINK_INTERVAL cycles of the new digits.
- R7: A rise of less than 25, or any fall, updates the display without any all-blank cycle.
- R8: An overflowing score never blinks, however large the jump.
- R9: The reference score becomes the new score whenever a conversion or an overflow display starts. This includes overflowing values.
- R10: A score change during a conversion or blink is not lost. Once the machine is idle again, the latest score is converted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| score | input | SCORE_W (14) | Unsigned score value |
| seg0 | output | 7 | Units digit segments, active low |
| seg1 | output | 7 | Tens digit segments, active low |
| seg2 | output | 7 | Hundreds digit segments, active low |
| seg3 | output | 7 | Thousands digit segments, active low |

## Verification
Overflow detection and jump detection can both hold for the same score change. A step from a small score to a value above 9999 satisfies both conditions at once. The bench drives such steps, both directed and random, and judges them by counting the all-blank runs seen on the outputs: the count must be zero, and the final pattern must be four dashes. The same run counter also checks the opposite case, where a fitting jump must produce exactly BLINK_COUNT blank runs, each of the exact length.

// File: rtl/score_disp_pkg.sv
package score_disp_pkg;

    typedef logic [6:0] seg_t;

    localparam seg_t SEG_BLANK = 7'h7F;
    localparam seg_t SEG_DASH  = 7'h3F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OVF,
        ST_D3,
        ST_D2,
        ST_D1,
        ST_D0,
        ST_BLINK,
        ST_COPY
    } state_e;

    // Decimal weight of a digit position.
    function automatic int pos_weight(input logic [1:0] pos);
        case (pos)
            2'd0:    return 1;
            2'd1:    return 10;
            2'd2:    return 100;
            default: return 1000;
        endcase
    endfunction

    // Digit to active-low segment vector, bit 0 = a ... bit 6 = g.
    function automatic seg_t digit_seg(input logic [3:0] d);
        logic [6:0] lit;
        case (d)
            4'd0:    lit = 7'h3F;
            4'd1:    lit = 7'h06;
            4'd2:    lit = 7'h5B;
            4'd3:    lit = 7'h4F;
            4'd4:    lit = 7'h66;
            4'd5:    lit = 7'h6D;
            4'd6:    lit = 7'h7D;
            4'd7:    lit = 7'h07;
            4'd8:    lit = 7'h7F;
            4'd9:    lit = 7'h6F;
            default: lit = 7'h00;
        endcase
        return ~lit;
    endfunction

endpackage

// File: rtl/score_seg_enc.sv
module score_seg_enc
    import score_disp_pkg::*;
(
    input  logic [3:0] digit,
    output seg_t       seg
);
    always_comb seg = digit_seg(digit);
endmodule

// File: rtl/score_blink_timer.sv
module score_blink_timer #(
    parameter int INTERVAL = 4,
    parameter int COUNT    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick,
    output logic phase_on,
    output logic last_rep
);
    localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam int REP_W = $clog2(COUNT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [REP_W-1:0] rep_q;
    logic             phase_q;

    assign tick     = (cnt_q == CNT_W'(INTERVAL - 1));
    assign phase_on = phase_q;
    assign last_rep = (rep_q == REP_W'(COUNT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            rep_q   <= '0;
        end else if (tick) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
            if (phase_q) rep_q <= rep_q + 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6
    rep_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (rep_q < REP_W'(COUNT)));

    // R6
    phase_len_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> (run -> $stable(phase_q)));

endmodule

// File: rtl/score_display.sv
module score_display
    import score_disp_pkg::*;
#(
    parameter int SCORE_W        = 14,
    parameter int BLINK_INTERVAL = 4,
    parameter int BLINK_COUNT    = 3,
    parameter int JUMP_MIN       = 25,
    parameter int MAX_SHOWN      = 9999
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SCORE_W-1:0] score,
    output logic [6:0]         seg0,
    output logic [6:0]         seg1,
    output logic [6:0]         seg2,
    output logic [6:0]         seg3
);
    localparam int NDIG = 4;
    localparam logic [SCORE_W-1:0] JUMP_L = SCORE_W'(JUMP_MIN);
    localparam logic [SCORE_W-1:0] MAX_L  = SCORE_W'(MAX_SHOWN);

    state_e               state_q;
    logic [SCORE_W-1:0]   ref_q;
    logic [SCORE_W-1:0]   work_q;
    logic [NDIG-1:0][3:0] dig_q;
    logic                 blink_q;
    seg_t [NDIG-1:0]      disp_q;
    seg_t [NDIG-1:0]      shown;

    logic [1:0]           pos;
    logic [SCORE_W-1:0]   step;
    logic                 can_sub;
    logic                 tick, phase_on, last_rep;

    for (genvar i = 0; i < NDIG; i++) begin : g_enc
        score_seg_enc u_enc (.digit(dig_q[i]), .seg(shown[i]));
    end

    score_blink_timer #(.INTERVAL(BLINK_INTERVAL), .COUNT(BLINK_COUNT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (state_q == ST_BLINK),
        .tick     (tick),
        .phase_on (phase_on),
        .last_rep (last_rep)
    );

    always_comb begin
        case (state_q)
            ST_D3:   pos = 2'd3;
            ST_D2:   pos = 2'd2;
            ST_D1:   pos = 2'd1;
            default: pos = 2'd0;
        endcase
        step    = SCORE_W'(pos_weight(pos));
        can_sub = (work_q >= step);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ref_q   <= '0;
            work_q  <= '0;
            dig_q   <= '0;
            blink_q <= 1'b0;
            disp_q  <= {NDIG{SEG_BLANK}};
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (score != ref_q) begin
                        ref_q   <= score;
                        work_q  <= score;
                        dig_q   <= '0;
                        blink_q <= (score > ref_q) && ((score - ref_q) >= JUMP_L);
                        state_q <= (score > MAX_L) ? ST_OVF : ST_D3;
                    end
                end
                ST_OVF: begin
                    disp_q  <= {NDIG{SEG_DASH}};
                    blink_q <= 1'b0;
                    state_q <= ST_IDLE;
                end
                ST_D3, ST_D2, ST_D1, ST_D0: begin
                    if (can_sub) begin
                        work_q     <= work_q - step;
                        dig_q[pos] <= dig_q[pos] + 4'd1;
                    end else begin
                        case (state_q)
                            ST_D3:   state_q <= ST_D2;
                            ST_D2:   state_q <= ST_D1;
                            ST_D1:   state_q <= ST_D0;
                            default: begin
                                if (blink_q) begin
                                    disp_q  <= {NDIG{SEG_BLANK}};
                                    state_q <= ST_BLINK;
                                end else begin
                                    state_q <= ST_COPY;
                                end
                            end
                        endcase
                    end
                end
                ST_BLINK: begin
                    if (tick) begin
                        if (!phase_on)     disp_q  <= shown;
                        else if (last_rep) state_q <= ST_COPY;
                        else               disp_q  <= {NDIG{SEG_BLANK}};
                    end
                end
                ST_COPY: begin
                    disp_q  <= shown;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign seg0 = disp_q[0];
    assign seg1 = disp_q[1];
    assign seg2 = disp_q[2];
    assign seg3 = disp_q[3];

    // R2
    reset_blank_chk: assert property (@(posedge clk)
        rst |=> (disp_q == {NDIG{SEG_BLANK}}));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && score == ref_q) |=> $stable(disp_q));

    // R5
    ovf_dash_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OVF) |=> (disp_q == {NDIG{SEG_DASH}}));

    // R8
    ovf_noblink_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OVF) |=> (state_q == ST_IDLE));

    // R9
    ref_update_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && score != ref_q) |=> (ref_q == $past(score)));

    // R4
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
        (dig_q[0] <= 4'd9) && (dig_q[1] <= 4'd9) && (dig_q[2] <= 4'd9) && (dig_q[3] <= 4'd9));

endmodule

// File: tb/score_display_tb.sv
module score_display_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SW    = 14;
    localparam int INTV  = 4;
    localparam int CNT   = 3;
    localparam int WIN   = 160;
    localparam logic [6:0] BLANK = 7'h7F;
    localparam logic [6:0] DASH  = 7'h3F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [SW-1:0] score = '0;
    logic [6:0]    seg0, seg1, seg2, seg3;

    int checks = 0;
    int fails  = 0;
    int ref_m  = 0;
    bit done   = 0;
    int unsigned seed_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    score_display #(.SCORE_W(SW), .BLINK_INTERVAL(INTV), .BLINK_COUNT(CNT)) u_dut (
        .clk(clk), .rst(rst), .score(score),
        .seg0(seg0), .seg1(seg1), .seg2(seg2), .seg3(seg3)
    );

    function automatic logic [6:0] exp_seg(input int d);
        logic [6:0] lit;
        case (d)
            0: lit = 7'b0111111; 1: lit = 7'b0000110; 2: lit = 7'b1011011;
            3: lit = 7'b1001111; 4: lit = 7'b1100110; 5: lit = 7'b1101101;
            6: lit = 7'b1111101; 7: lit = 7'b0000111; 8: lit = 7'b1111111;
            default: lit = 7'b1101111;
        endcase
        return ~lit;
    endfunction

    function automatic logic [27:0] exp_disp(input int v);
        if (v > 9999) return {4{DASH}};
        return {exp_seg((v / 1000) % 10), exp_seg((v / 100) % 10),
                exp_seg((v / 10) % 10), exp_seg(v % 10)};
    endfunction

    function automatic bit blinks(input int from, input int to);
        return (to > from) && (to - from >= 25) && (to <= 9999);
    endfunction

    function automatic logic [27:0] cur();
        return {seg3, seg2, seg1, seg0};
    endfunction

    function automatic bit all_blank(input logic [27:0] d);
        return d == {4{BLANK}};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [27:0] act, input logic [27:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply v; optionally change to mid after 3 cycles. Watch the outputs for WIN cycles.
    task automatic apply(input int v, input int mid);
        logic [27:0] prev, d;
        int runs = 0, run_len = 0, bad_len = 0, changes = 0, exp_runs = 0, final_v;
        bit counting = 0, changed;
        @(negedge clk);
        prev = cur();
        score = SW'(v);
        changed = (v != ref_m);
        if (changed) begin
            exp_runs = blinks(ref_m, v) ? CNT : 0;
            ref_m = v;
        end
        final_v = v;
        for (int c = 0; c < WIN; c++) begin
            @(negedge clk);
            if (c == 2 && mid >= 0) begin
                score = SW'(mid);
                if (mid != ref_m) begin
                    exp_runs += blinks(ref_m, mid) ? CNT : 0;
                    ref_m = mid;
                    changed = 1;
                end
                final_v = mid;
            end
            d = cur();
            if (d != prev) changes++;
            if (all_blank(d) && !all_blank(prev)) begin
                runs++; run_len = 1; counting = 1;
            end else if (all_blank(d) && counting) begin
                run_len++;
            end else if (!all_blank(d) && counting) begin
                if (run_len != INTV) bad_len++;
                counting = 0;
            end
            prev = d;
        end
        if (changed) begin
            // R4 R5 R10: settled value
            chk(cur() == exp_disp(final_v), (final_v > 9999) ? "R5 dash on overflow" :
                (mid >= 0 ? "R10 latest score shown" : "R4 decimal result"), cur(), exp_disp(final_v));
            // R6 R7 R8: blank run count
            chk(runs == exp_runs, (v > 9999) ? "R8 no blink on overflow" :
                (exp_runs > 0 ? "R6 blink run count" : "R7 no blank cycle"),
                28'(runs), 28'(exp_runs));
            if (exp_runs > 0) chk(bad_len == 0, "R6 blank run length", 28'(bad_len), 28'd0);
        end else begin
            // R3: unchanged score keeps outputs
            chk(changes == 0, "R3 outputs held", 28'(changes), 28'd0);
        end
    endtask

    initial begin
        seed_v = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        // R2: reset blanks outputs, score 0 equals reference 0
        chk(cur() == {4{BLANK}}, "R2 reset blank", cur(), {4{BLANK}});
        apply(0, -1);
        apply(7, -1);
        // R1: digit patterns and position order
        chk(seg0 == 7'b1111000 && seg3 == 7'b1000000, "R1 active-low map", cur(), exp_disp(7));
        apply(88, -1);
        chk(seg0 == 7'h00 && seg1 == 7'h00 && seg2 == 7'h40, "R1 digit eight", cur(), exp_disp(88));
        apply(112, -1);       // +24, R7
        apply(137, -1);       // +25, R6
        apply(9999, -1);      // big rise, R6 at upper bound
        apply(10000, -1);     // R5 R8
        apply(9999, -1);      // fall from overflow, R7 R9
        apply(9999, -1);      // R3
        apply(100, -1);
        apply(16383, -1);     // R8 with huge jump
        apply(16383, -1);     // R3 during dashes
        apply(20, -1);        // R9: reference was 16383, fall
        apply(45, -1);        // +25 from 20, R6 R9
        apply(50, 60);        // R10
        apply(62, -1);
        for (int i = 0; i < 40; i++) begin
            int v;
            case ($urandom % 4)
                0: v = ref_m + int'($urandom % 50);
                1: v = int'($urandom % 10000);
                2: v = int'($urandom % 16384);
                default: v = ref_m;
            endcase
            if (v > 16383) v = 16383;
            apply(v, -1);
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule